// File: doc/BRIEF.md
# Horner Shift-Add Constant Multiplier

This block scales a signed fixed-point sample by a constant fraction fixed at build time. No multiplier is used: the set bits of the constant are visited from the least significant end. A running value is shifted right by the gap to the next set bit and the sample is added back in. A last right shift, equal to the distance of the leading set bit from the binary point, completes the product. With this chain, a constant with k set bits costs k-1 adders and no partial-product array.

Each set bit owns one pipeline register, so a new sample enters every cycle and leaves after as many cycles as the constant has set bits. The sample is carried through the pipeline with enough guard bits that every shift is exact. The product is then negated when requested and rounded to an integer result. A negative lifting coefficient is built by setting the negate parameter on the magnitude pattern.

Top module: `horner_cmul`

## Requirements
- R1: When valid_o is high, data_o equals floor((x*C + 2^(FRAC_W-1)) / 2^FRAC_W), with x the signed sample and C the unsigned integer value of the COEFF bit pattern (weight of bit i is 2^(i-FRAC_W)). This is round-half-up of x*C/2^FRAC_W, with no error beyond the rounding.
- R2: A sample taken with valid_i high appears on data_o with valid_o high exactly N cycles later, N being the number of set bits in COEFF.
- R3: Samples on consecutive cycles are all accepted and each gives its own correct result on consecutive cycles.
- R4: A cycle with valid_i low produces a cycle with valid_o low N cycles later. Gaps in the input are kept in the output.
- R5: With NEGATE set, data_o equals floor((-x*C + 2^(FRAC_W-1)) / 2^FRAC_W). The product is negated before rounding.
- R6: The full input range, including -2^(DATA_W-1) and 2^(DATA_W-1)-1, gives correct results with no internal overflow. The sign of each running value follows the sign of the sample.
- R7: While rst_ni is low, valid_o is low.
- R8: A zero sample gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample on data_i is valid |
| data_i | input | DATA_W | Signed input sample |
| valid_o | output | 1 | Result on data_o is valid |
| data_o | output | OUT_W | Signed rounded product |

## Verification
Every result is due exactly N rising edges after its sample was driven, where N is the set-bit count of the constant. With the 0.110011001100 pattern N is six; for the second instance, which uses 0.011100011000 and negation, N is five. The bench works N out from its own copy of each constant. It keeps a per-instance history of the driven samples and valid flags. At every falling edge it compares valid_o and data_o against the entry driven N cycles before, and only then drives the next sample. Valid gaps, back-to-back runs and extreme values therefore all line up with the cycle in which they must leave.

// File: rtl/horner_pkg.sv
package horner_pkg;

  function automatic int set_count(input logic [31:0] c);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) if (c[i]) n++;
    return n;
  endfunction

  // bit index of the k-th set bit counted from the LSB
  function automatic int set_pos(input logic [31:0] c, input int k);
    int n;
    int pos;
    n   = 0;
    pos = 0;
    for (int i = 0; i < 32; i++) begin
      if (c[i]) begin
        if (n == k) pos = i;
        n++;
      end
    end
    return pos;
  endfunction

  function automatic int stage_shift(input logic [31:0] c, input int k);
    int s;
    if (k == 0) s = 0;
    else        s = set_pos(c, k) - set_pos(c, k - 1);
    return s;
  endfunction

endpackage

// File: rtl/horner_stage.sv
module horner_stage #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12,
  parameter int ACC_W  = DATA_W + FRAC_W + 2,
  parameter int SHIFT  = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic                     vld_o,
  output logic signed [DATA_W-1:0] x_o,
  output logic signed [ACC_W-1:0]  acc_o
);

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] acc_nxt;

  always_comb begin
    x_ext   = ACC_W'(x_i) <<< FRAC_W;
    acc_nxt = (acc_i >>> SHIFT) + x_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      x_o   <= '0;
      acc_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        x_o   <= x_i;
        acc_o <= acc_nxt;
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (acc_o[ACC_W-1] == acc_o[ACC_W-2]));

  // R6
  sign_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && x_o != '0) |-> (acc_o[ACC_W-1] == x_o[DATA_W-1]));

  // R8
  zero_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ((acc_o == '0) == (x_o == '0)));

endmodule

// File: rtl/horner_round.sv
module horner_round #(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 12,
  parameter int ACC_W    = DATA_W + FRAC_W + 2,
  parameter int OUT_W    = DATA_W + 1,
  parameter int FINAL_SH = 1,
  parameter bit NEGATE   = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [OUT_W-1:0]  y_o
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);

  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] rnd;
  logic        [OUT_W:0]   y_mag;
  logic        [OUT_W:0]   x_mag;

  always_comb begin
    prod = acc_i >>> FINAL_SH;
    if (NEGATE) prod = -prod;
    rnd  = (prod + HALF) >>> FRAC_W;
    y_o  = rnd[OUT_W-1:0];
  end

  always_comb begin
    y_mag = y_o[OUT_W-1] ? (OUT_W+1)'(-(OUT_W+1)'(y_o)) : (OUT_W+1)'(y_o);
    x_mag = x_i[DATA_W-1] ? (OUT_W+1)'(-(OUT_W+1)'(x_i)) : (OUT_W+1)'(x_i);
  end

  // R1
  mag_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> (y_mag <= x_mag));

  // R8
  zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && x_i == '0) |-> (y_o == '0));

endmodule

// File: rtl/horner_cmul.sv
module horner_cmul
  import horner_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                FRAC_W = 12,
  parameter logic [FRAC_W-1:0] COEFF  = 12'b110011001100,
  parameter bit                NEGATE = 1'b0,
  parameter int                OUT_W  = DATA_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  data_o
);

  localparam int ACC_W    = DATA_W + FRAC_W + 2;
  localparam int N_SET    = set_count(32'(COEFF));
  localparam int MSB_POS  = set_pos(32'(COEFF), N_SET - 1);
  localparam int FINAL_SH = FRAC_W - MSB_POS;

  logic                     vld_s [N_SET+1];
  logic signed [DATA_W-1:0] x_s   [N_SET+1];
  logic signed [ACC_W-1:0]  acc_s [N_SET+1];

  assign vld_s[0] = valid_i;
  assign x_s[0]   = data_i;
  assign acc_s[0] = '0;

  for (genvar k = 0; k < N_SET; k++) begin : g_stage
    horner_stage #(
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W),
      .ACC_W (ACC_W),
      .SHIFT (stage_shift(32'(COEFF), k))
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld_s[k]),
      .x_i   (x_s[k]),
      .acc_i (acc_s[k]),
      .vld_o (vld_s[k+1]),
      .x_o   (x_s[k+1]),
      .acc_o (acc_s[k+1])
    );
  end

  horner_round #(
    .DATA_W  (DATA_W),
    .FRAC_W  (FRAC_W),
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .FINAL_SH(FINAL_SH),
    .NEGATE  (NEGATE)
  ) u_round (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_s[N_SET]),
    .x_i   (x_s[N_SET]),
    .acc_i (acc_s[N_SET]),
    .y_o   (data_o)
  );

  assign valid_o = vld_s[N_SET];

  // R7
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

endmodule

// File: tb/horner_cmul_bench.sv
module horner_cmul_bench;

  localparam int          DW  = 16;
  localparam int          FW  = 12;
  localparam logic [11:0] CA  = 12'b110011001100;
  localparam logic [11:0] CB  = 12'b011100011000;
  localparam int          NA  = $countones(CA);
  localparam int          NBB = $countones(CB);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 vin = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic                 va, vb;
  logic signed [DW:0]   da, db;

  always #4 clk = ~clk;

  horner_cmul #(.DATA_W(DW), .FRAC_W(FW), .COEFF(CA), .NEGATE(1'b0)) u_horner_cmul (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .data_i(din), .valid_o(va), .data_o(da));

  horner_cmul #(.DATA_W(DW), .FRAC_W(FW), .COEFF(CB), .NEGATE(1'b1)) u_horner_cmul_neg (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .data_i(din), .valid_o(vb), .data_o(db));

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  logic  hv [0:15];
  logic signed [DW-1:0] hx [0:15];
  string hr [0:15];

  function automatic longint model(input longint x, input longint c, input bit neg);
    longint p;
    p = x * c;
    if (neg) p = -p;
    return (p + 2048) >>> 12;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic signed [DW-1:0] x, input string req);
    longint ea, eb;
    check(va == hv[NA-1], hv[NA-1] ? "R2" : "R4", "valid_o A", va, hv[NA-1]);
    if (hv[NA-1]) begin
      ea = model(hx[NA-1], CA, 1'b0);
      check(longint'(da) == ea, hr[NA-1], "data_o A", da, ea);
    end
    check(vb == hv[NBB-1], hv[NBB-1] ? "R2" : "R4", "valid_o B", vb, hv[NBB-1]);
    if (hv[NBB-1]) begin
      eb = model(hx[NBB-1], CB, 1'b1);
      check(longint'(db) == eb, "R5", "data_o B", db, eb);
    end
    for (int i = 15; i > 0; i--) begin
      hv[i] = hv[i-1];
      hx[i] = hx[i-1];
      hr[i] = hr[i-1];
    end
    hv[0] = v;
    hx[0] = x;
    hr[0] = req;
    vin   = v;
    din   = x;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      hv[i] = 1'b0;
      hx[i] = '0;
      hr[i] = "R1";
    end
    repeat (3) @(negedge clk);
    check(!va && !vb, "R7", "valid_o in reset", {va, vb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 16'sd0, "R8");
    step(1'b1, 16'sd32767, "R6");
    step(1'b1, -16'sd32768, "R6");
    step(1'b1, -16'sd1, "R1");
    step(1'b1, 16'sd1, "R1");
    step(1'b0, 16'sd123, "R4");
    step(1'b0, -16'sd77, "R4");
    step(1'b1, 16'sd5, "R1");
    step(1'b0, 16'sd0, "R4");
    for (int i = 0; i < 6; i++)
      step(1'b1, (i % 2 == 0) ? -16'sd32768 : 16'sd32767, "R3");
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, DW'($urandom), "R1");
    for (int i = 0; i < 20; i++)
      step(1'b0, '0, "R4");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule